// File: doc/BRIEF.md
# Ancestry-Path Memory Access Checker

This block rules on every read, write or delete that a processor socket issues against a memory region. The processor does not state who it is. The block takes the requester's identity from a table indexed by socket number, and only the task dispatcher can fill that table. Each table row holds the ancestry path of the task that currently occupies the socket. The path is a list of task IDs that starts at the root, and the last entry is the task's own ID.

A request supplies three things: the ancestry path of the task that created the region, the operation, and a small set of additional permission entries for the region. The requester gets full access when its whole path is a leading part of the creator's path. When that test fails, an entry in the region's list can still grant the one operation it enables, but only if its path is exactly equal to the requester's path. The answer appears a fixed two clock edges after the request is sampled.

The dispatcher cannot put a reserved task ID (devices, controller, dispatcher) into a socket, and it cannot write a path that is longer than the table holds. A task ID of zero stands for "no task" and is never granted anything.

Top module: `accessChkTop`

## Requirements
- R1: While reset is low and after it is released, every socket is unmapped (length 0), respValid and respGrant are low, and a request from any socket is denied.
- R2: A request sampled at clock edge k gives respValid high after edge k+1 and at no other time. Back-to-back requests each get their own answer. respGrant is low whenever respValid is low.
- R3: With opcode 0 (read), 1 (write) or 2 (delete), the request is granted when the requester's length is no greater than the creator's length, the creator's length is at most DEPTH, and the first requester-length entries of the two paths are equal. Entries beyond a path's length are ignored.
- R4: When the requester's path is longer than the creator's path, or differs from it at any position inside the requester's length, the prefix test gives no grant.
- R5: An additional entry grants the requested operation when its valid bit is set, its length and first entries equal the requester's path exactly, and its permission bit for that operation is set. Permission bit 0 is read, bit 1 is write, bit 2 is delete.
- R6: An additional entry does not grant when its valid bit is clear, when its permission bit for the operation is clear, or when its path is only a prefix or an extension of the requester's path.
- R7: A requester whose socket length is 0, or whose own task ID (the last path entry) is 0, is denied every operation, even when the prefix test or an additional entry would match.
- R8: Opcode 3 is denied.
- R9: A dispatcher write is ignored, and the socket keeps its previous path, when the written length exceeds DEPTH or the written task ID lies in 1..RSVD_IDS. A write of length 0 unmaps the socket.
- R10: Identity comes only from the socket table. A request sampled on the same edge as a dispatcher write to its socket is judged with the path held before that write.
- R11: A creator length above DEPTH never grants through the prefix test, but additional entries still apply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| mapWrEn | input | 1 | Dispatcher writes a socket's ancestry path |
| mapSocket | input | $clog2(NSOCK) | Socket being written |
| mapPath | input | DEPTH*IDW | Path to store; entry i at bits i*IDW, entry 0 is the root |
| mapLen | input | $clog2(DEPTH+1) | Number of valid entries in mapPath |
| reqValid | input | 1 | Access request present |
| reqSocket | input | $clog2(NSOCK) | Socket issuing the request |
| reqOp | input | 2 | 0 read, 1 write, 2 delete, 3 illegal |
| ownerPath | input | DEPTH*IDW | Creator's ancestry path, same layout as mapPath |
| ownerLen | input | $clog2(DEPTH+1) | Creator's path length |
| extraValid | input | NEXTRA | Valid bit per additional entry |
| extraPerm | input | 3*NEXTRA | Per entry: bit 0 read, bit 1 write, bit 2 delete |
| extraLen | input | NEXTRA*$clog2(DEPTH+1) | Path length per entry |
| extraPath | input | NEXTRA*DEPTH*IDW | Entry e, element i at bits (e*DEPTH+i)*IDW |
| respValid | output | 1 | Decision present |
| respGrant | output | 1 | Access granted |

## Verification
The main decision is tried against creator paths that equal the requester's path, extend it, cut it short, and differ at the root or at an inner position. These separate a correct prefix test from one that compares only lengths, only the root, or that accepts paths of either direction of inclusion. Additional entries are tried as exact copies with a single permission bit, invalid copies, prefixes, extensions, and copies placed in the second slot. These show that the match is exact and that each permission bit is selected by the opcode. Zero task IDs, reserved-ID and oversize dispatcher writes, and a dispatcher write on the same edge as a request test the identity path. A random phase then mixes all of these on consecutive cycles.

// File: rtl/accessChkPkg.sv
package accessChkPkg;

  typedef enum logic [1:0] {
    OP_READ   = 2'd0,
    OP_WRITE  = 2'd1,
    OP_DELETE = 2'd2,
    OP_NONE   = 2'd3
  } accessOpE;

  // strobes from control to datapath
  typedef struct packed {
    logic mapLoad;   // accepted dispatcher write
    logic capture;   // latch request and requester identity
    logic decide;    // produce a decision this edge
  } strobeS;

endpackage

// File: rtl/accessChkCtrl.sv
module accessChkCtrl
  import accessChkPkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int IDW      = 8,
  parameter int RSVD_IDS = 3,
  localparam int LENW    = $clog2(DEPTH + 1)
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            mapWrEn,
  input  logic [LENW-1:0] mapLen,
  input  logic [IDW-1:0]  mapTail,
  input  logic            reqValid,
  output strobeS          strobes,
  output logic            respValid
);

  logic stageValid;
  logic mapOk;
  logic tailReserved;

  always_comb begin
    tailReserved = (mapTail >= IDW'(1)) && (mapTail <= IDW'(RSVD_IDS));
    mapOk = (mapLen == '0) ||
            ((mapLen <= LENW'(DEPTH)) && !tailReserved);
    strobes.mapLoad = mapWrEn && mapOk;
    strobes.capture = reqValid;
    strobes.decide  = stageValid;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stageValid <= 1'b0;
      respValid  <= 1'b0;
    end else begin
      stageValid <= reqValid;
      respValid  <= stageValid;
    end
  end

endmodule

// File: rtl/accessChkData.sv
module accessChkData
  import accessChkPkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int IDW    = 8,
  parameter int NSOCK  = 4,
  parameter int NEXTRA = 2,
  localparam int LENW  = $clog2(DEPTH + 1),
  localparam int SOCKW = (NSOCK > 1) ? $clog2(NSOCK) : 1,
  localparam int PATHW = DEPTH * IDW
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  strobeS                   strobes,
  input  logic [SOCKW-1:0]         mapSocket,
  input  logic [PATHW-1:0]         mapPath,
  input  logic [LENW-1:0]          mapLen,
  input  logic [SOCKW-1:0]         reqSocket,
  input  logic [1:0]               reqOp,
  input  logic [PATHW-1:0]         ownerPath,
  input  logic [LENW-1:0]          ownerLen,
  input  logic [NEXTRA-1:0]        extraValid,
  input  logic [3*NEXTRA-1:0]      extraPerm,
  input  logic [NEXTRA*LENW-1:0]   extraLen,
  input  logic [NEXTRA*PATHW-1:0]  extraPath,
  output logic                     respGrant
);

  // socket-to-task identity table
  logic [PATHW-1:0] sockPath [NSOCK];
  logic [LENW-1:0]  sockLen  [NSOCK];

  // captured request
  logic [PATHW-1:0]        stPath;
  logic [LENW-1:0]         stLen;
  accessOpE                stOp;
  logic [PATHW-1:0]        stOwnPath;
  logic [LENW-1:0]         stOwnLen;
  logic [NEXTRA-1:0]       stExtValid;
  logic [3*NEXTRA-1:0]     stExtPerm;
  logic [NEXTRA*LENW-1:0]  stExtLen;
  logic [NEXTRA*PATHW-1:0] stExtPath;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < NSOCK; s++) begin
        sockPath[s] <= '0;
        sockLen[s]  <= '0;
      end
    end else if (strobes.mapLoad) begin
      sockPath[mapSocket] <= mapPath;
      sockLen[mapSocket]  <= mapLen;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stPath     <= '0;
      stLen      <= '0;
      stOp       <= OP_NONE;
      stOwnPath  <= '0;
      stOwnLen   <= '0;
      stExtValid <= '0;
      stExtPerm  <= '0;
      stExtLen   <= '0;
      stExtPath  <= '0;
    end else if (strobes.capture) begin
      stPath     <= sockPath[reqSocket];
      stLen      <= sockLen[reqSocket];
      stOp       <= accessOpE'(reqOp);
      stOwnPath  <= ownerPath;
      stOwnLen   <= ownerLen;
      stExtValid <= extraValid;
      stExtPerm  <= extraPerm;
      stExtLen   <= extraLen;
      stExtPath  <= extraPath;
    end
  end

  // requester's own task ID is the last entry inside its length
  logic [IDW-1:0] reqTail;
  always_comb begin
    reqTail = '0;
    for (int i = 0; i < DEPTH; i++)
      if (LENW'(i + 1) == stLen) reqTail = stPath[i*IDW +: IDW];
  end

  // per-position agreement with the creator path
  logic [DEPTH-1:0] ownAgree;
  logic [NEXTRA-1:0] extraHitVec;

  for (genvar i = 0; i < DEPTH; i++) begin : g_own
    assign ownAgree[i] = (LENW'(i) >= stLen) ||
                         (stPath[i*IDW +: IDW] == stOwnPath[i*IDW +: IDW]);
  end

  for (genvar e = 0; e < NEXTRA; e++) begin : g_extra
    logic [DEPTH-1:0] agree;
    logic             permBit;
    for (genvar i = 0; i < DEPTH; i++) begin : g_pos
      assign agree[i] = (LENW'(i) >= stLen) ||
        (stPath[i*IDW +: IDW] == stExtPath[(e*DEPTH+i)*IDW +: IDW]);
    end
    always_comb begin
      unique case (stOp)
        OP_READ:   permBit = stExtPerm[3*e];
        OP_WRITE:  permBit = stExtPerm[3*e+1];
        OP_DELETE: permBit = stExtPerm[3*e+2];
        default:   permBit = 1'b0;
      endcase
    end
    assign extraHitVec[e] = stExtValid[e] && permBit && (&agree) &&
                            (stExtLen[e*LENW +: LENW] == stLen);
  end

  logic reqOk, opOk, prefixHit, grantNext;
  always_comb begin
    reqOk     = (reqTail != '0);
    opOk      = (stOp != OP_NONE);
    prefixHit = (stOwnLen <= LENW'(DEPTH)) && (stLen <= stOwnLen) && (&ownAgree);
    grantNext = reqOk && opOk && (prefixHit || (|extraHitVec));
  end

  always_ff @(posedge clk) begin
    if (!rstN) respGrant <= 1'b0;
    else       respGrant <= strobes.decide && grantNext;
  end

endmodule

// File: rtl/accessChkTop.sv
module accessChkTop
  import accessChkPkg::*;
#(
  parameter int DEPTH    = 8,
  parameter int IDW      = 8,
  parameter int NSOCK    = 4,
  parameter int NEXTRA   = 2,
  parameter int RSVD_IDS = 3,
  localparam int LENW    = $clog2(DEPTH + 1),
  localparam int SOCKW   = (NSOCK > 1) ? $clog2(NSOCK) : 1,
  localparam int PATHW   = DEPTH * IDW
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic                     mapWrEn,
  input  logic [SOCKW-1:0]         mapSocket,
  input  logic [PATHW-1:0]         mapPath,
  input  logic [LENW-1:0]          mapLen,
  input  logic                     reqValid,
  input  logic [SOCKW-1:0]         reqSocket,
  input  logic [1:0]               reqOp,
  input  logic [PATHW-1:0]         ownerPath,
  input  logic [LENW-1:0]          ownerLen,
  input  logic [NEXTRA-1:0]        extraValid,
  input  logic [3*NEXTRA-1:0]      extraPerm,
  input  logic [NEXTRA*LENW-1:0]   extraLen,
  input  logic [NEXTRA*PATHW-1:0]  extraPath,
  output logic                     respValid,
  output logic                     respGrant
);

  strobeS         strobes;
  logic [IDW-1:0] mapTail;

  always_comb begin
    mapTail = '0;
    for (int i = 0; i < DEPTH; i++)
      if (LENW'(i + 1) == mapLen) mapTail = mapPath[i*IDW +: IDW];
  end

  accessChkCtrl #(.DEPTH(DEPTH), .IDW(IDW), .RSVD_IDS(RSVD_IDS)) u_ctrl (
    .clk(clk), .rstN(rstN), .mapWrEn(mapWrEn), .mapLen(mapLen),
    .mapTail(mapTail), .reqValid(reqValid), .strobes(strobes),
    .respValid(respValid)
  );

  accessChkData #(.DEPTH(DEPTH), .IDW(IDW), .NSOCK(NSOCK), .NEXTRA(NEXTRA)) u_data (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .mapSocket(mapSocket), .mapPath(mapPath), .mapLen(mapLen),
    .reqSocket(reqSocket), .reqOp(reqOp),
    .ownerPath(ownerPath), .ownerLen(ownerLen),
    .extraValid(extraValid), .extraPerm(extraPerm),
    .extraLen(extraLen), .extraPath(extraPath),
    .respGrant(respGrant)
  );

endmodule

// File: rtl/accessChkSva.sv
module accessChkSva (
  input logic       clk,
  input logic       rstN,
  input logic       reqValid,
  input logic [1:0] reqOp,
  input logic       respValid,
  input logic       respGrant
);

  // R1: reset leaves the output quiet
  a_r1_reset_quiet: assert property (@(posedge clk)
    !rstN |=> (!respValid && !respGrant));

  // R2: every request answered two edges later
  a_r2_latency: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> ##1 respValid);

  // R2: no answer without a request
  a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rstN)
    respValid |-> $past(reqValid, 2));

  // R2: grant only alongside a decision
  a_r2_grant_qualified: assert property (@(posedge clk) disable iff (!rstN)
    respGrant |-> respValid);

  // R8: illegal opcode denied
  a_r8_bad_op: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqOp == 2'b11) |=> ##1 (respValid && !respGrant));

endmodule

bind accessChkTop accessChkSva u_sva (
  .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqOp(reqOp),
  .respValid(respValid), .respGrant(respGrant)
);

// File: tb/sim_accessChkTop.sv
module sim_accessChkTop;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 8, IDW = 8, NSOCK = 4, NEXTRA = 2, RSVD_IDS = 3;
  localparam int LENW = $clog2(DEPTH + 1);
  localparam int SOCKW = $clog2(NSOCK);
  localparam int PATHW = DEPTH * IDW;

  logic clk = 0, rstN = 0;
  logic mapWrEn, reqValid;
  logic [SOCKW-1:0] mapSocket, reqSocket;
  logic [PATHW-1:0] mapPath, ownerPath;
  logic [LENW-1:0] mapLen, ownerLen;
  logic [1:0] reqOp;
  logic [NEXTRA-1:0] extraValid;
  logic [3*NEXTRA-1:0] extraPerm;
  logic [NEXTRA*LENW-1:0] extraLen;
  logic [NEXTRA*PATHW-1:0] extraPath;
  logic respValid, respGrant;

  accessChkTop u0 (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  // reference state
  int sockP [NSOCK][DEPTH];
  int sockL [NSOCK];
  // stimulus variables
  int mEn, mSock, mP[DEPTH], mL;
  int rV, rSock, rOp, oP[DEPTH], oL;
  int xV[NEXTRA], xPerm[NEXTRA], xL[NEXTRA], xP[NEXTRA][DEPTH];
  // expected pipeline
  bit v1, v2, g1, g2;
  string t1, t2;
  int vectors = 0, fails = 0;
  bit done = 0;

  task automatic packPorts();
    mapWrEn = (mEn != 0); mapSocket = SOCKW'(mSock); mapLen = LENW'(mL);
    reqValid = (rV != 0); reqSocket = SOCKW'(rSock); reqOp = 2'(rOp);
    ownerLen = LENW'(oL);
    for (int i = 0; i < DEPTH; i++) begin
      mapPath[i*IDW +: IDW] = IDW'(mP[i]);
      ownerPath[i*IDW +: IDW] = IDW'(oP[i]);
    end
    for (int e = 0; e < NEXTRA; e++) begin
      extraValid[e] = (xV[e] != 0);
      extraPerm[3*e +: 3] = 3'(xPerm[e]);
      extraLen[e*LENW +: LENW] = LENW'(xL[e]);
      for (int i = 0; i < DEPTH; i++)
        extraPath[(e*DEPTH+i)*IDW +: IDW] = IDW'(xP[e][i]);
    end
  endtask

  function automatic bit model(output string tag);
    int len, tail;
    bit hit;
    len = sockL[rSock];
    tail = (len >= 1 && len <= DEPTH) ? sockP[rSock][len-1] : 0;
    if (len == 0 || tail == 0) begin tag = "R7"; return 0; end
    if (rOp == 3) begin tag = "R8"; return 0; end
    if (oL <= DEPTH && len <= oL) begin
      hit = 1;
      for (int i = 0; i < len; i++) if (sockP[rSock][i] != oP[i]) hit = 0;
      if (hit) begin tag = "R3"; return 1; end
    end
    for (int e = 0; e < NEXTRA; e++) begin
      if (xV[e] != 0 && xL[e] == len && ((xPerm[e] >> rOp) & 1) != 0) begin
        hit = 1;
        for (int i = 0; i < len; i++) if (sockP[rSock][i] != xP[e][i]) hit = 0;
        if (hit) begin tag = "R5"; return 1; end
      end
    end
    tag = (oL > DEPTH) ? "R11" : "R4/R6";
    return 0;
  endfunction

  task automatic modelMap();
    int tail;
    tail = (mL >= 1 && mL <= DEPTH) ? mP[mL-1] : 0;
    if (mL == 0 || (mL <= DEPTH && !(tail >= 1 && tail <= RSVD_IDS))) begin
      sockL[mSock] = mL;
      for (int i = 0; i < DEPTH; i++) sockP[mSock][i] = mP[i];
    end
  endtask

  task automatic step(input string note = "");
    bit eg;
    string et;
    packPorts();
    eg = 0; et = "R2";
    if (rV != 0) eg = model(et);
    if (note != "") et = {et, " ", note};
    @(posedge clk);
    if (!rstN) begin
      for (int s = 0; s < NSOCK; s++) sockL[s] = 0;
      v1 = 0; v2 = 0; g1 = 0; g2 = 0;
    end else begin
      if (mEn != 0) modelMap();
      v2 = v1; g2 = g1; t2 = t1;
      v1 = (rV != 0); g1 = eg; t1 = et;
    end
    @(negedge clk);
    vectors++;
    if (respValid !== v2) begin
      fails++;
      $display("FAIL R2 respValid actual=%b expected=%b", respValid, v2);
    end else if (respGrant !== (v2 && g2)) begin
      fails++;
      $display("FAIL %s respGrant actual=%b expected=%b", v2 ? t2 : "R2",
               respGrant, v2 && g2);
    end
    rV = 0; mEn = 0;
  endtask

  task automatic setPath(output int p[DEPTH], input int a, b, c, d);
    for (int i = 0; i < DEPTH; i++) p[i] = 200 + i;
    p[0] = a; p[1] = b; p[2] = c; p[3] = d;
  endtask

  task automatic doMap(input int s, a, b, c, d, len);
    mEn = 1; mSock = s; mL = len; setPath(mP, a, b, c, d); step();
  endtask

  task automatic doReq(input int s, op, a, b, c, d, len, input string note);
    rV = 1; rSock = s; rOp = op; oL = len; setPath(oP, a, b, c, d); step(note);
  endtask

  task automatic setExtra(input int e, v, perm, a, b, c, d, len);
    int tmp[DEPTH];
    xV[e] = v; xPerm[e] = perm; xL[e] = len;
    setPath(tmp, a, b, c, d);
    for (int i = 0; i < DEPTH; i++) xP[e][i] = tmp[i];
  endtask

  task automatic clearExtras();
    for (int e = 0; e < NEXTRA; e++) setExtra(e, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin
    mEn = 0; mSock = 0; mL = 0; rV = 0; rSock = 0; rOp = 0; oL = 0;
    for (int i = 0; i < DEPTH; i++) begin mP[i] = 0; oP[i] = 0; end
    clearExtras();
    v1 = 0; v2 = 0; g1 = 0; g2 = 0; t1 = ""; t2 = "";
    @(negedge clk);
    // R1: reset, including a request held during reset
    rstN = 0;
    for (int k = 0; k < 3; k++) begin rV = 1; rSock = k; step("R1 in reset"); end
    rstN = 1;
    doReq(0, 0, 10, 20, 30, 0, 3, "R1 unmapped");
    step(); step();

    doMap(0, 10, 20, 0, 0, 2);
    doMap(1, 10, 0, 0, 0, 1);
    doMap(2, 10, 20, 30, 0, 3);
    // R3 prefix grants, all ops, equal and longer creator
    doReq(0, 0, 10, 20, 30, 0, 3, "R3 read");
    doReq(0, 1, 10, 20, 30, 0, 3, "R3 write");
    doReq(0, 2, 10, 20, 30, 40, 4, "R3 delete");
    doReq(0, 0, 10, 20, 0, 0, 2, "R3 equal");
    // R4 non-prefix
    doReq(2, 0, 10, 20, 0, 0, 2, "R4 longer");
    doReq(0, 1, 10, 21, 30, 0, 3, "R4 inner");
    doReq(0, 2, 11, 20, 30, 0, 3, "R4 root");
    // R8 illegal opcode
    doReq(1, 3, 10, 20, 0, 0, 2, "R8");
    // R5 / R6 extra entries
    setExtra(0, 1, 1, 10, 20, 30, 0, 3);
    doReq(2, 0, 50, 0, 0, 0, 1, "R5 read bit");
    doReq(2, 1, 50, 0, 0, 0, 1, "R6 no write bit");
    doReq(2, 2, 50, 0, 0, 0, 1, "R6 no delete bit");
    setExtra(0, 1, 6, 10, 20, 30, 0, 3);
    doReq(2, 1, 50, 0, 0, 0, 1, "R5 write bit");
    doReq(2, 2, 50, 0, 0, 0, 1, "R5 delete bit");
    setExtra(0, 0, 7, 10, 20, 30, 0, 3);
    doReq(2, 0, 50, 0, 0, 0, 1, "R6 invalid");
    setExtra(0, 1, 7, 10, 20, 0, 0, 2);
    doReq(2, 0, 50, 0, 0, 0, 1, "R6 prefix only");
    setExtra(0, 1, 7, 10, 20, 30, 40, 4);
    doReq(2, 0, 50, 0, 0, 0, 1, "R6 extension");
    setExtra(1, 1, 2, 10, 20, 30, 0, 3);
    doReq(2, 1, 50, 0, 0, 0, 1, "R5 slot1");
    clearExtras();
    // R7 zero task ID
    doMap(3, 10, 0, 0, 0, 2);
    doReq(3, 0, 10, 0, 5, 0, 3, "R7 zero tail prefix");
    setExtra(0, 1, 7, 10, 0, 0, 0, 2);
    doReq(3, 0, 60, 0, 0, 0, 1, "R7 zero tail extra");
    clearExtras();
    // R9 reserved and oversize writes ignored
    doMap(1, 10, 2, 0, 0, 2);
    doReq(1, 0, 10, 0, 0, 0, 1, "R9 reserved ignored");
    doMap(1, 10, 20, 30, 40, 9);
    doReq(1, 1, 10, 0, 0, 0, 1, "R9 oversize ignored");
    doMap(0, 0, 0, 0, 0, 0);
    doReq(0, 0, 10, 20, 0, 0, 2, "R9 R7 unmapped");
    // R11 oversize creator
    doReq(1, 0, 10, 0, 0, 0, 9, "R11 prefix blocked");
    setExtra(1, 1, 1, 10, 0, 0, 0, 1);
    doReq(1, 0, 10, 0, 0, 0, 9, "R11 extra applies");
    clearExtras();
    // R10 same-edge write uses old identity
    mEn = 1; mSock = 2; mL = 1; setPath(mP, 99, 0, 0, 0);
    doReq(2, 0, 10, 20, 30, 0, 3, "R10 old identity");
    doReq(2, 0, 10, 20, 30, 0, 3, "R10 new identity");
    step(); step();

    // random mix, back to back
    for (int n = 0; n < 400; n++) begin
      int s, len, k;
      if ($urandom_range(0, 3) == 0) begin
        mEn = 1; mSock = $urandom_range(0, NSOCK-1); mL = $urandom_range(0, DEPTH+1);
        for (int i = 0; i < DEPTH; i++) mP[i] = $urandom_range(0, 6);
      end
      s = $urandom_range(0, NSOCK-1); len = sockL[s];
      rV = ($urandom_range(0, 4) != 0); rSock = s; rOp = $urandom_range(0, 3);
      for (int i = 0; i < DEPTH; i++) oP[i] = (i < len) ? sockP[s][i] : $urandom_range(0, 6);
      oL = len + $urandom_range(0, 2) - 1;
      if (oL < 0) oL = 0;
      if (oL > DEPTH + 1) oL = DEPTH + 1;
      if ($urandom_range(0, 3) == 0) begin
        k = $urandom_range(0, DEPTH-1); oP[k] = $urandom_range(0, 6);
      end
      for (int e = 0; e < NEXTRA; e++) begin
        xV[e] = $urandom_range(0, 1); xPerm[e] = $urandom_range(0, 7);
        xL[e] = ($urandom_range(0, 1) != 0) ? len : $urandom_range(0, DEPTH);
        for (int i = 0; i < DEPTH; i++)
          xP[e][i] = ($urandom_range(0, 4) != 0 && i < len) ? sockP[s][i] : $urandom_range(0, 6);
      end
      step("random");
    end
    clearExtras();
    step(); step();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule